// File: doc/BRIEF.md
# Panel Power-Up Register Sequencer

This block brings an external LCD timing controller from reset to a lit display. A host pulses `start`. The block samples the panel width and height, asks the board for a controller reset and waits for the acknowledge. It then issues a fixed script of register writes, each one an (address, data) pair. The script depends on which of the four supported panel sizes was selected. The writes go to a downstream serializer over a valid/ready port.

The script has timed pauses. One comes after the clock-multiplier setup and one after the pixel-clock setup. Two more come at the end, around the display-enable write. Pause lengths are counted in whole milliseconds, from a clock-frequency parameter. A size outside the supported four raises a sticky error and emits nothing. A completed script raises a sticky `done` flag.

Top module: `disp_init_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `rst_req`, `wr_valid`, `done` and `err` are all 0.
- R2: `start` with a supported size raises `rst_req` on the next clock. `rst_req` stays high, with `wr_valid` low, until `rst_ack` is sampled high; it drops on that same edge. No write is issued before then.
- R3: A supported size produces exactly 19 writes (address=data, hex), in this order:
  - 88=PLL_A, 89=02, 10=0C, 04=PCLK, 14..18, 19..1F, 8A=81, 8B=FF, 01=80.
  - PLL_A is 0A for widths 320 and 480, and 0B for 640 and 800.
  - PCLK is 03, 82, 01 or 81 for 320x240, 480x272, 640x480 and 800x480.
  - Bytes 15..18 are 00 05 04 03 / 00 01 00 05 / 05 0F 01 00 / 03 03 02 00 for those same sizes.
  - Bytes 1B..1F are 05 00 0E 00 02 / 02 00 07 00 09 / 0A 00 0E 00 01 / 14 00 06 00 01.
- R4: Register 14 carries width/8-1. Registers 19 and 1A carry the low and high bytes of height-1.
- R5: While `wr_valid` is high and `wr_ready` low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R6: With M = CLK_HZ/1000 cycles per millisecond, pauses fall at three points:
  - Before the 10=0C write, `wr_valid` rises 3+10·M cycles after the previous write's handshake edge.
  - Before the 14 write, it rises 3+M cycles after.
  - Before the 01=80 write, it rises 3+10·M cycles after.
  - Every other write follows its predecessor's handshake by 1 cycle.
  - No write is offered during a pause.
- R7: `done` rises 3+10·M cycles after the handshake of the 01=80 write. It stays high, with no further writes or reset requests, until the next `start`, which clears it.
- R8: `start` with any other width/height pair sets `err` on the next clock. It then never raises `rst_req` or `wr_valid`. `err` holds until the next `start`.
- R9: `start` while a sequence is in progress is ignored.
- R10: The panel size is sampled only at the accepted `start`. Later changes to `hres`/`vres` do not alter the running script.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| hres | input | WB | Panel width in pixels |
| vres | input | HB | Panel height in lines |
| rst_req | output | 1 | Controller reset request |
| rst_ack | input | 1 | Controller reset completed |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Downstream accepts the write |
| wr_addr | output | 8 | Register address |
| wr_data | output | 8 | Register data |
| done | output | 1 | Sequence completed (sticky) |
| err | output | 1 | Unsupported size (sticky) |

## Verification
Some properties are checked on every cycle by the assertions:
- a stalled write holds stable;
- no write appears while a reset request or a pause is pending, or while `done` or `err` is set;
- the reset request drops the edge it is acknowledged;
- `done` persists until `start`.

Other behaviour needs the bench's reference model, which runs all four sizes with and without back-pressure:
- the exact address/data order;
- the size-derived bytes;
- the pause lengths measured in cycles between handshakes;
- that a mid-run `start` or a mid-run size change leaves the script untouched.

// File: rtl/disp_init_pkg.sv
package disp_init_pkg;
  typedef enum logic [1:0] {K_WR, K_WAIT, K_END} kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [7:0]  addr;
    logic [7:0]  data;
    logic [3:0]  ms;
  } step_t;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_FETCH, S_WRITE, S_WAIT} st_e;

  localparam int N_SIZES = 4;
  localparam int N_STEPS = 24;
  localparam int STEP_W  = $clog2(N_STEPS);

  function automatic int unsigned panel_w(input logic [1:0] i);
    case (i)
      2'd0:    return 320;
      2'd1:    return 480;
      2'd2:    return 640;
      default: return 800;
    endcase
  endfunction

  function automatic int unsigned panel_h(input logic [1:0] i);
    case (i)
      2'd0:    return 240;
      2'd1:    return 272;
      default: return 480;
    endcase
  endfunction
endpackage

// File: rtl/disp_size_decode.sv
module disp_size_decode
  import disp_init_pkg::*;
#(
  parameter int WB = 12,
  parameter int HB = 12
) (
  input  logic [WB-1:0] hres,
  input  logic [HB-1:0] vres,
  output logic          ok,
  output logic [1:0]    idx
);
  always_comb begin
    ok  = 1'b0;
    idx = '0;
    for (int i = 0; i < N_SIZES; i++) begin
      if (32'(hres) == panel_w(2'(i)) && 32'(vres) == panel_h(2'(i))) begin
        ok  = 1'b1;
        idx = 2'(i);
      end
    end
  end
endmodule

// File: rtl/disp_step_rom.sv
module disp_step_rom
  import disp_init_pkg::*;
(
  input  logic [1:0]        idx,
  input  logic [STEP_W-1:0] step,
  output step_t             ent
);
  logic [31:0] htab;
  logic [39:0] vtab;
  logic [7:0]  pclk;
  logic [7:0]  wdiv;
  logic [15:0] hm1;

  always_comb begin
    case (idx)
      2'd0: begin htab = 32'h00050403; vtab = 40'h05000E0002; pclk = 8'h03; end
      2'd1: begin htab = 32'h00010005; vtab = 40'h0200070009; pclk = 8'h82; end
      2'd2: begin htab = 32'h050F0100; vtab = 40'h0A000E0001; pclk = 8'h01; end
      default: begin htab = 32'h03030200; vtab = 40'h1400060001; pclk = 8'h81; end
    endcase
    wdiv = 8'(panel_w(idx) / 8 - 1);
    hm1  = 16'(panel_h(idx) - 1);
  end

  function automatic step_t mk(kind_e k, logic [7:0] a, logic [7:0] d, logic [3:0] m);
    step_t s;
    s.kind = k; s.addr = a; s.data = d; s.ms = m;
    return s;
  endfunction

  always_comb begin
    ent = mk(K_END, 8'h00, 8'h00, 4'd0);
    case (step)
      5'd0:  ent = mk(K_WR, 8'h88, idx[1] ? 8'h0B : 8'h0A, 4'd0);
      5'd1:  ent = mk(K_WR, 8'h89, 8'h02, 4'd0);
      5'd2:  ent = mk(K_WAIT, 8'h00, 8'h00, 4'd10);
      5'd3:  ent = mk(K_WR, 8'h10, 8'h0C, 4'd0);
      5'd4:  ent = mk(K_WR, 8'h04, pclk, 4'd0);
      5'd5:  ent = mk(K_WAIT, 8'h00, 8'h00, 4'd1);
      5'd6:  ent = mk(K_WR, 8'h14, wdiv, 4'd0);
      5'd7, 5'd8, 5'd9, 5'd10:
             ent = mk(K_WR, 8'h0E + 8'(step), 8'(htab >> (8 * (10 - int'(step)))), 4'd0);
      5'd11: ent = mk(K_WR, 8'h19, hm1[7:0], 4'd0);
      5'd12: ent = mk(K_WR, 8'h1A, hm1[15:8], 4'd0);
      5'd13, 5'd14, 5'd15, 5'd16, 5'd17:
             ent = mk(K_WR, 8'h0E + 8'(step), 8'(vtab >> (8 * (17 - int'(step)))), 4'd0);
      5'd18: ent = mk(K_WR, 8'h8A, 8'h81, 4'd0);
      5'd19: ent = mk(K_WR, 8'h8B, 8'hFF, 4'd0);
      5'd20: ent = mk(K_WAIT, 8'h00, 8'h00, 4'd10);
      5'd21: ent = mk(K_WR, 8'h01, 8'h80, 4'd0);
      5'd22: ent = mk(K_WAIT, 8'h00, 8'h00, 4'd10);
      default: ent = mk(K_END, 8'h00, 8'h00, 4'd0);
    endcase
  end
endmodule

// File: rtl/disp_ms_timer.sv
module disp_ms_timer #(
  parameter int CYC_PER_MS = 100000,
  parameter int MS_W       = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [MS_W-1:0] ms,
  output logic            busy,
  output logic            fire
);
  localparam int CW = $clog2(CYC_PER_MS + 1);
  localparam logic [CW-1:0] CYC_LAST = CW'(CYC_PER_MS - 1);

  logic [CW-1:0]   cyc;
  logic [MS_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      fire <= 1'b0;
      cyc  <= '0;
      left <= '0;
    end else begin
      fire <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        cyc  <= '0;
        left <= ms;
      end else if (busy) begin
        if (cyc == CYC_LAST) begin
          cyc <= '0;
          if (left <= MS_W'(1)) begin
            busy <= 1'b0;
            fire <= 1'b1;
          end else begin
            left <= left - 1'b1;
          end
        end else begin
          cyc <= cyc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/disp_init_seq.sv
module disp_init_seq
  import disp_init_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int WB     = 12,
  parameter int HB     = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [WB-1:0] hres,
  input  logic [HB-1:0] vres,
  output logic          rst_req,
  input  logic          rst_ack,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [7:0]    wr_addr,
  output logic [7:0]    wr_data,
  output logic          done,
  output logic          err
);
  localparam int CYC_PER_MS = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;

  st_e               st;
  logic [STEP_W-1:0] step;
  logic [1:0]        idx_q;
  logic              sz_ok;
  logic [1:0]        sz_idx;
  step_t             ent;
  logic              tmr_load, tmr_busy, tmr_fire;

  disp_size_decode #(.WB(WB), .HB(HB)) u_dec (
    .hres(hres), .vres(vres), .ok(sz_ok), .idx(sz_idx)
  );

  disp_step_rom u_rom (.idx(idx_q), .step(step), .ent(ent));

  assign tmr_load = (st == S_FETCH) && (ent.kind == K_WAIT);

  disp_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(4)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .ms(ent.ms),
    .busy(tmr_busy), .fire(tmr_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      step     <= '0;
      idx_q    <= '0;
      rst_req  <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          done <= 1'b0;
          err  <= 1'b0;
          if (sz_ok) begin
            idx_q   <= sz_idx;
            rst_req <= 1'b1;
            st      <= S_RST;
          end else begin
            err <= 1'b1;
          end
        end
        S_RST: if (rst_ack) begin
          rst_req <= 1'b0;
          step    <= '0;
          st      <= S_FETCH;
        end
        S_FETCH: begin
          case (ent.kind)
            K_WR: begin
              wr_valid <= 1'b1;
              wr_addr  <= ent.addr;
              wr_data  <= ent.data;
              st       <= S_WRITE;
            end
            K_WAIT: st <= S_WAIT;
            default: begin
              done <= 1'b1;
              st   <= S_IDLE;
            end
          endcase
        end
        S_WRITE: if (wr_ready) begin
          wr_valid <= 1'b0;
          step     <= step + 1'b1;
          st       <= S_FETCH;
        end
        S_WAIT: if (tmr_fire) begin
          step <= step + 1'b1;
          st   <= S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_no_write_in_reset: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !wr_valid);
  a_r2_ack_release: assert property (@(posedge clk) disable iff (rst)
    rst_req && rst_ack |=> !rst_req);
  a_r5_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  a_r6_quiet_pause: assert property (@(posedge clk) disable iff (rst)
    tmr_busy |-> !wr_valid);
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_valid && !rst_req);
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
    err |-> !wr_valid && !rst_req);
endmodule

// File: tb/test_disp_init_seq.sv
`timescale 1ns/1ps
module test_disp_init_seq;
  localparam int CLK_HZ = 8000;
  localparam int CPM    = CLK_HZ / 1000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, rst_ack = 1'b0, wr_ready = 1'b0;
  logic [11:0] hres = '0, vres = '0;
  logic rst_req, wr_valid, done, err;
  logic [7:0] wr_addr, wr_data;

  disp_init_seq #(.CLK_HZ(CLK_HZ), .WB(12), .HB(12)) i_disp_init_seq (
    .clk(clk), .rst(rst), .start(start), .hres(hres), .vres(vres),
    .rst_req(rst_req), .rst_ack(rst_ack), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .err(err)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, hs_edge = 0;
  bit stall = 1'b0;
  logic [15:0] exp_q[$];
  int          gap_q[$];

  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic push(logic [7:0] a, logic [7:0] d, int g);
    exp_q.push_back({a, d});
    gap_q.push_back(g);
  endtask

  // Reference script built from the stated requirements (R3, R4, R6)
  task automatic build(int w, int h);
    logic [7:0] hb[4];
    logic [7:0] vb[5];
    logic [7:0] pc;
    exp_q.delete(); gap_q.delete();
    case (w)
      320: begin hb = '{8'h00,8'h05,8'h04,8'h03}; vb = '{8'h05,8'h00,8'h0E,8'h00,8'h02}; pc = 8'h03; end
      480: begin hb = '{8'h00,8'h01,8'h00,8'h05}; vb = '{8'h02,8'h00,8'h07,8'h00,8'h09}; pc = 8'h82; end
      640: begin hb = '{8'h05,8'h0F,8'h01,8'h00}; vb = '{8'h0A,8'h00,8'h0E,8'h00,8'h01}; pc = 8'h01; end
      default: begin hb = '{8'h03,8'h03,8'h02,8'h00}; vb = '{8'h14,8'h00,8'h06,8'h00,8'h01}; pc = 8'h81; end
    endcase
    push(8'h88, (w >= 640) ? 8'h0B : 8'h0A, 0);
    push(8'h89, 8'h02, 1);
    push(8'h10, 8'h0C, 3 + 10 * CPM);
    push(8'h04, pc, 1);
    push(8'h14, 8'(w / 8 - 1), 3 + CPM);
    for (int i = 0; i < 4; i++) push(8'h15 + 8'(i), hb[i], 1);
    push(8'h19, 8'((h - 1) % 256), 1);
    push(8'h1A, 8'((h - 1) / 256), 1);
    for (int i = 0; i < 5; i++) push(8'h1B + 8'(i), vb[i], 1);
    push(8'h8A, 8'h81, 1);
    push(8'h8B, 8'hFF, 1);
    push(8'h01, 8'h80, 3 + 10 * CPM);
  endtask

  // Per-clock comparison against the reference queue
  bit pv = 0, pr = 0, pdone = 0;
  logic [7:0] pa = 0, pd = 0;
  always @(negedge clk) begin
    bit rdy;
    rdy = stall ? ((cyc % 3) != 1) : 1'b1;
    wr_ready = rdy;
    if (!rst) begin
      if (wr_valid) begin
        if (!pv) begin
          if (exp_q.size() == 0) chk(0, "R3 unexpected write", {wr_addr, wr_data}, 0);
          else if (gap_q[0] != 0)
            chk(cyc - hs_edge == gap_q[0], "R6 write gap", cyc - hs_edge, gap_q[0]);
        end
        if (pv && !pr) chk(wr_addr == pa && wr_data == pd, "R5 stall hold", {wr_addr, wr_data}, {pa, pd});
        if (exp_q.size() > 0) chk({wr_addr, wr_data} == exp_q[0], "R3/R4 write value", {wr_addr, wr_data}, exp_q[0]);
        if (rdy) begin
          hs_edge = cyc + 1;
          if (exp_q.size() > 0) begin void'(exp_q.pop_front()); void'(gap_q.pop_front()); end
        end
      end
      if (done && !pdone) begin
        chk(cyc - hs_edge == 3 + 10 * CPM, "R7 done timing", cyc - hs_edge, 3 + 10 * CPM);
        chk(exp_q.size() == 0, "R3 writes missing", exp_q.size(), 0);
      end
    end
    pv = wr_valid; pr = rdy; pa = wr_addr; pd = wr_data; pdone = done;
  end

  task automatic run_seq(int w, int h, bit stl, bit corrupt, bit poke);
    int n;
    build(w, h);
    stall = stl; hres = 12'(w); vres = 12'(h);
    start = 1; @(negedge clk); start = 0;
    chk(rst_req == 1, "R2 reset request", rst_req, 1);
    chk(done == 0 && err == 0, "R7 start clears done", {done, err}, 0);
    if (corrupt) begin hres = 12'd1024; vres = 12'd768; end
    repeat (4) begin
      @(negedge clk);
      chk(rst_req && !wr_valid, "R2 wait for ack", {rst_req, wr_valid}, 2'b10);
    end
    rst_ack = 1; @(negedge clk); rst_ack = 0;
    chk(!rst_req, "R2 release", rst_req, 0);
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk); n++;
      start = (poke && n == 40);
      chk(!rst_req, "R9 no restart", rst_req, 0);
    end
    start = 0;
    chk(done, "R7 done raised", done, 1);
    repeat (20) begin
      @(negedge clk);
      chk(done && !wr_valid && !rst_req, "R7 done held", {done, wr_valid, rst_req}, 3'b100);
    end
  endtask

  task automatic run_bad(int w, int h);
    hres = 12'(w); vres = 12'(h);
    start = 1; @(negedge clk); start = 0;
    chk(err == 1, "R8 error flag", err, 1);
    repeat (30) begin
      @(negedge clk);
      chk(err && !rst_req && !wr_valid && !done, "R8 quiet error", {err, rst_req, wr_valid, done}, 4'b1000);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rst_req && !wr_valid && !done && !err, "R1 reset state", {rst_req, wr_valid, done, err}, 0);
    rst = 0;
    @(negedge clk);
    chk(!rst_req && !wr_valid && !done && !err, "R1 after reset", {rst_req, wr_valid, done, err}, 0);
    run_seq(800, 480, 0, 0, 0);
    run_seq(320, 240, 1, 0, 0);
    run_seq(480, 272, 1, 0, 1);   // R9 mid-run start
    run_seq(640, 480, 0, 1, 0);   // R10 size change after start
    run_bad(1024, 600);
    run_bad(800, 240);
    run_seq(480, 272, 0, 0, 0);   // R8 error cleared by a good start
    report();
  end
endmodule